// File: doc/BRIEF.md
# Cascadable Successive Approximation Register Slice

This block is the digital half of a successive approximation converter. On an accepted start it loads a trial word with only the top bit set and hands it to an external DAC. On each later clock it reads one comparator decision. The decision keeps or drops the bit under trial, and the next lower bit then becomes the trial bit. After the lowest bit is decided, the slice raises a one-cycle `done` pulse and holds the result word until the next accepted start. Each decided bit also appears on a serial output, most significant first.

Three ways of wiring set the word length and the cadence:

- **Shorter words.** Tying one of the slice's own result bits to its `trunc` input ends the conversion early. For example, tying bit 1 gives a 6-bit word in bits 7..2.
- **Continuous conversion.** Tying `done` to `start` makes the slice convert back to back without stopping.
- **Wider words.** Two slices can be chained. An upstream slice built with `SELF_START=1` cannot stay idle after reset. A downstream slice with `SELF_START=0` waits in its cleared state for the upstream `done`. The downstream `done`, fed back to the upstream `start`, keeps the pair recycling.

Top module: `sar_slice`

## Requirements
- R1: A low `rst_n` at a clock edge clears `trial`, `ser_out` and `done` to 0. A slice built with `SELF_START=0` then stays idle with `trial` at 0 until `start` is seen high.
- R2: When the slice is not converting and samples `start` high at an edge, `trial` becomes 1 at bit WIDTH-1 and 0 elsewhere after that edge, and `done` is low.
- R3: On each later edge of a conversion, the bit under trial takes the value of `cmp_keep`, and the next lower bit is set to 1. Here `cmp_keep`=1 means the trial word is less than or equal to the input. With the bench comparator `trial <= target`, the final word equals the 8-bit target.
- R4: For an untruncated conversion, `done` is high in the cycle after the edge that decides bit 0, which is the 8th edge after the start edge for WIDTH=8. It stays high for exactly one cycle. After that, `trial` keeps the result until the next accepted start.
- R5: After each deciding edge, `ser_out` equals the bit just decided, so the result leaves most significant bit first.
- R6: `start` sampled during a conversion has no effect. The conversion carries on and ends on its original schedule with its own result.
- R7: When `trunc` is high at an edge during a conversion, that edge clears the bit under trial, sets no lower bit and ends the conversion, with `done` high in the following cycle. When this collides with the decision of bit 0, bit 0 is cleared. With `trunc` tied to `trial[1]`, the result is the target with bits 1..0 cleared, and done pulses arrive every 8 cycles when `done` feeds `start`.
- R8: With `done` fed back to `start`, a new conversion is accepted on the edge right after the done pulse, so an 8-bit slice produces a result every 9 cycles. Holding `start` high gives the same 9-cycle cadence.
- R9: A slice built with `SELF_START=1` starts a conversion on the first edge after reset without `start`. After a conversion it waits for `start` like any other slice.
- R10: In a two-slice 12-bit chain, each slice's `start` is fed by the other's `done`. The downstream slice is truncated with `trunc` tied to its `trial[3]`. The chain delivers the 12-bit result {upstream `trial`, downstream `trial[7:4]`} with a done pulse every 15 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a conversion, sampled only while not converting |
| cmp_keep | input | 1 | Comparator decision for the bit under trial (1 keeps it) |
| trunc | input | 1 | Ends the running conversion at this edge and withdraws the current trial bit |
| trial | output | WIDTH | Trial word during a conversion, result word afterwards; drives the DAC |
| ser_out | output | 1 | Most recently decided bit |
| done | output | 1 | One-cycle pulse after the edge that completes a conversion |

## Verification
The riskiest coincidence is a request to start arriving on the same edge that completes a conversion, or a truncation arriving on the same edge as the decision of bit 0. The bench holds `start` high through whole conversions and pulses it in the middle of one. It expects the done spacing to stay at 9 cycles and the results to be untouched. It also raises `trunc` exactly on the bit-0 deciding edge and expects bit 0 to be withdrawn, with the done pulse on schedule. Sweeps over every code of the 6-, 8- and 12-bit arrangements, timed from done pulse to done pulse, confirm that restart and completion never overlap.

// File: rtl/sar_pkg.sv
// Shared types for the successive approximation slice.
// Assumes: the controller is the only user of the state encoding.
package sar_pkg;

    // Controller state: cleared after reset, converting, or holding a result.
    typedef enum logic [1:0] {
        SAR_EMPTY = 2'd0,
        SAR_RUN   = 2'd1,
        SAR_HOLD  = 2'd2
    } sar_state_e;

endpackage

// File: rtl/sar_ctrl.sv
// Conversion sequencer: accepts a start, turns each edge of a conversion into
// either a decision or a truncation, and reports the completing edge.
// Assumes: ptr_lsb is high exactly when bit 0 is under trial.
module sar_ctrl
    import sar_pkg::*;
#(
    parameter bit SELF_START = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       trunc,
    input  logic       ptr_lsb,
    output sar_state_e state_q,
    output logic       load,
    output logic       decide,
    output logic       withdraw,
    output logic       finish
);

    sar_state_e state_d;
    logic       idle;
    logic       auto_go;

    // Classify the coming edge: accept a start, decide a bit, or truncate.
    always_comb begin
        idle     = (state_q != SAR_RUN);
        auto_go  = SELF_START && (state_q == SAR_EMPTY);
        load     = idle && (start || auto_go);
        withdraw = !idle && trunc;
        decide   = !idle && !trunc;
        finish   = withdraw || (decide && ptr_lsb);
    end

    // Next state: load enters a conversion, a completing edge leaves it.
    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = SAR_RUN;
        end else if (finish) begin
            state_d = SAR_HOLD;
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SAR_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/sar_pointer.sv
// One-hot marker of the bit under trial. It enters at the top on load, steps
// down one place per decision, and empties on the completing edge.
// Assumes: load, decide and finish come from sar_ctrl.
module sar_pointer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             decide,
    input  logic             finish,
    output logic [WIDTH-1:0] ptr
);

    // chain[WIDTH] is a constant empty stage above the top bit.
    logic [WIDTH:0] chain;
    assign chain[WIDTH] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic stage_q;

        // Marker stage i: set on load at the top, else fed from the stage above.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q <= 1'b0;
            end else if (load) begin
                stage_q <= (i == WIDTH - 1);
            end else if (finish) begin
                stage_q <= 1'b0;
            end else if (decide) begin
                stage_q <= chain[i+1];
            end
        end

        assign chain[i] = stage_q;
        assign ptr[i]   = stage_q;
    end

endmodule

// File: rtl/sar_result.sv
// Trial/result register. Each bit is loaded, decided, withdrawn, or set as
// the next trial bit according to the marker position.
// Assumes: ptr is one-hot during a conversion and all zero otherwise.
module sar_result #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             decide,
    input  logic             withdraw,
    input  logic             cmp_keep,
    input  logic [WIDTH-1:0] ptr,
    output logic [WIDTH-1:0] trial
);

    // above[i] is high when the bit just above i is under trial.
    logic [WIDTH:0] above;
    assign above[WIDTH] = 1'b0;
    assign above[WIDTH-1:0] = {1'b0, ptr[WIDTH-1:1]};

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic bit_q;

        // Result bit i: top-only on load, decision or withdrawal under trial, trial set below.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (load) begin
                bit_q <= (i == WIDTH - 1);
            end else if (ptr[i] && withdraw) begin
                bit_q <= 1'b0;
            end else if (ptr[i] && decide) begin
                bit_q <= cmp_keep;
            end else if (above[i] && decide) begin
                bit_q <= 1'b1;
            end
        end

        assign trial[i] = bit_q;
    end

endmodule

// File: rtl/sar_serial.sv
// Output stage: shows each decided bit on the serial pin and turns the
// completing edge into a one-cycle done pulse.
// Assumes: decide and finish come from sar_ctrl.
module sar_serial (
    input  logic clk,
    input  logic rst_n,
    input  logic decide,
    input  logic finish,
    input  logic cmp_keep,
    output logic ser_out,
    output logic done
);

    // Serial bit: capture each decision as it is made.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_out <= 1'b0;
        end else if (decide) begin
            ser_out <= cmp_keep;
        end
    end

    // Done pulse: high for the cycle after a completing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= finish;
        end
    end

endmodule

// File: rtl/sar_slice.sv
// Cascadable successive approximation register slice.
// Sequencer, trial marker, result register and serial/done stage wired together.
// Assumes: the external comparator settles within one clock of a trial change.
module sar_slice
    import sar_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter bit SELF_START = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_keep,
    input  logic             trunc,
    output logic [WIDTH-1:0] trial,
    output logic             ser_out,
    output logic             done
);

    sar_state_e       state_q;
    logic             load;
    logic             decide;
    logic             withdraw;
    logic             finish;
    logic             busy;
    logic [WIDTH-1:0] ptr;

    assign busy = (state_q == SAR_RUN);

    sar_ctrl #(
        .SELF_START(SELF_START)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .trunc   (trunc),
        .ptr_lsb (ptr[0]),
        .state_q (state_q),
        .load    (load),
        .decide  (decide),
        .withdraw(withdraw),
        .finish  (finish)
    );

    sar_pointer #(
        .WIDTH(WIDTH)
    ) u_pointer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .decide(decide),
        .finish(finish),
        .ptr   (ptr)
    );

    sar_result #(
        .WIDTH(WIDTH)
    ) u_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .decide  (decide),
        .withdraw(withdraw),
        .cmp_keep(cmp_keep),
        .ptr     (ptr),
        .trial   (trial)
    );

    sar_serial u_serial (
        .clk     (clk),
        .rst_n   (rst_n),
        .decide  (decide),
        .finish  (finish),
        .cmp_keep(cmp_keep),
        .ser_out (ser_out),
        .done    (done)
    );

endmodule

// File: rtl/sar_slice_check.sv
// Property checker for sar_slice, bound to every instance.
// Assumes: busy and ptr are the slice's own conversion flag and trial marker.
module sar_slice_check #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             cmp_keep,
    input logic             trunc,
    input logic [WIDTH-1:0] trial,
    input logic             ser_out,
    input logic             done,
    input logic             busy,
    input logic [WIDTH-1:0] ptr
);

    localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (trial == '0 && !done && !ser_out));

    assert_load_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (trial == TOP_ONLY && busy && !done));

    assert_one_marker_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $onehot(ptr));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(trial));

    assert_serial_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !trunc) |=> (ser_out == $past(cmp_keep)));

    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !trunc && !ptr[0]) |=> busy);

    assert_trunc_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trunc) |=> (done && !busy));

endmodule

bind sar_slice sar_slice_check #(
    .WIDTH(WIDTH)
) u_sar_slice_check (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cmp_keep(cmp_keep),
    .trunc   (trunc),
    .trial   (trial),
    .ser_out (ser_out),
    .done    (done),
    .busy    (busy),
    .ptr     (ptr)
);

// File: tb/sar_slice_bench.sv
// Bench: one externally driven 8-bit slice, one self-starting slice truncated
// to 6 bits, and a two-slice 12-bit chain, each with a digital comparator model.
module sar_slice_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10ns clk = ~clk;

    int total_n = 0;
    int pass_n  = 0;
    int fail_n  = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total_n++;
        if (ok) pass_n++;
        else begin
            fail_n++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", pass_n, total_n);
    endtask

    // Expected trial word after k deciding edges (k = 0 is the load edge).
    function automatic logic [7:0] exp_trial(input logic [7:0] t, input int k);
        logic [7:0] mask;
        logic [7:0] r;
        mask = (k == 0) ? 8'h00 : 8'(8'hFF << (8 - k));
        r = t & mask;
        if (k < 8) r = r | 8'(8'h80 >> k);
        return r;
    endfunction

    // Externally driven 8-bit slice
    logic       s8_start_drv = 1'b0;
    logic       s8_loop = 1'b0;
    logic       s8_cut = 1'b0;
    logic [7:0] s8_tgt = 8'h00;
    logic [7:0] s8_q;
    logic       s8_ser;
    logic       s8_done;
    logic       s8_start;
    logic       s8_cmp;
    assign s8_start = s8_start_drv | (s8_loop & s8_done);
    assign s8_cmp   = (s8_q <= s8_tgt);

    sar_slice #(.WIDTH(8), .SELF_START(1'b0)) u_sar_slice (
        .clk(clk), .rst_n(rst_n), .start(s8_start), .cmp_keep(s8_cmp),
        .trunc(s8_cut), .trial(s8_q), .ser_out(s8_ser), .done(s8_done)
    );

    // Self-starting slice truncated to 6 bits by its own bit 1
    logic [7:0] sh_tgt = 8'h03;
    logic [7:0] sh_q;
    logic       sh_ser;
    logic       sh_done;
    logic       sh_cmp;
    assign sh_cmp = (sh_q <= sh_tgt);

    sar_slice #(.WIDTH(8), .SELF_START(1'b1)) u_sar_slice_short (
        .clk(clk), .rst_n(rst_n), .start(sh_done), .cmp_keep(sh_cmp),
        .trunc(sh_q[1]), .trial(sh_q), .ser_out(sh_ser), .done(sh_done)
    );

    // 12-bit chain: upstream self-starting, downstream truncated by its bit 3
    logic [11:0] tgt12 = 12'h000;
    logic [7:0]  hi_q, lo_q;
    logic        hi_ser, lo_ser, hi_done, lo_done;
    logic        hi_cmp, lo_cmp;
    assign hi_cmp = ({hi_q, 4'h0} <= tgt12);
    assign lo_cmp = ({hi_q, lo_q[7:4]} <= tgt12);

    sar_slice #(.WIDTH(8), .SELF_START(1'b1)) u_sar_slice_hi (
        .clk(clk), .rst_n(rst_n), .start(lo_done), .cmp_keep(hi_cmp),
        .trunc(1'b0), .trial(hi_q), .ser_out(hi_ser), .done(hi_done)
    );

    sar_slice #(.WIDTH(8), .SELF_START(1'b0)) u_sar_slice_lo (
        .clk(clk), .rst_n(rst_n), .start(hi_done), .cmp_keep(lo_cmp),
        .trunc(lo_q[3]), .trial(lo_q), .ser_out(lo_ser), .done(lo_done)
    );

    // Truncated-slice sweep monitor: all 64 codes (R7)
    int sh_code = 0;
    int sh_cnt  = 0;
    bit sh_seen = 1'b0;
    bit sh_fin  = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !sh_fin) begin
            sh_cnt++;
            if (sh_done) begin
                chk(sh_q == (sh_tgt & 8'hFC), "R7 six-bit result", sh_q, sh_tgt & 8'hFC);
                if (sh_seen) chk(sh_cnt == 8, "R7 six-bit period", sh_cnt, 8);
                sh_seen = 1'b1;
                sh_cnt  = 0;
                if (sh_code == 63) sh_fin = 1'b1;
                else begin
                    sh_code++;
                    sh_tgt = {sh_code[5:0], 2'($urandom)};
                end
            end
        end
    end

    // Chain sweep monitor: all 4096 codes (R10)
    int cas_code = 0;
    int cas_cnt  = 0;
    bit cas_seen = 1'b0;
    bit cas_fin  = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !cas_fin) begin
            cas_cnt++;
            if (lo_done) begin
                chk({hi_q, lo_q} == {tgt12, 4'h0}, "R10 twelve-bit result", {hi_q, lo_q}, {tgt12, 4'h0});
                if (cas_seen) chk(cas_cnt == 15, "R10 twelve-bit period", cas_cnt, 15);
                cas_seen = 1'b1;
                cas_cnt  = 0;
                if (cas_code == 4095) cas_fin = 1'b1;
                else begin
                    cas_code++;
                    tgt12 = 12'(cas_code);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        report();
        $finish;
    end

    // Wait for the external slice's done pulse; counts negedges, first one drops start.
    task automatic wait_done(output int n);
        n = 0;
        do begin
            @(negedge clk);
            if (n == 0) s8_start_drv = 1'b0;
            n++;
        end while (!s8_done && n < 40);
    endtask

    initial begin
        int unsigned seed_v;
        int n;
        logic [7:0] fixed_t [4];
        seed_v = $urandom(32'h5A17);
        fixed_t[0] = 8'h00; fixed_t[1] = 8'hFF; fixed_t[2] = 8'h80; fixed_t[3] = 8'h7F;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(s8_q == 8'h00 && !s8_done && !s8_ser, "R1 reset state", {s8_q, s8_done, s8_ser}, 0);
        chk(sh_q == 8'h00 && hi_q == 8'h00, "R1 reset state others", {sh_q, hi_q}, 0);
        rst_n = 1'b1;

        // R9: self-start after reset, others stay idle
        @(negedge clk);
        chk(sh_q == 8'h80, "R9 self start short", sh_q, 8'h80);
        chk(hi_q == 8'h80, "R9 self start upstream", hi_q, 8'h80);
        chk(lo_q == 8'h00, "R9 downstream waits", lo_q, 0);
        repeat (4) @(negedge clk);
        chk(s8_q == 8'h00 && !s8_done, "R1 idle without start", s8_q, 0);

        // R2, R3, R4, R5: step-by-step trace
        s8_tgt = 8'hA5;
        s8_start_drv = 1'b1;
        @(negedge clk);
        s8_start_drv = 1'b0;
        chk(s8_q == 8'h80 && !s8_done, "R2 load word", s8_q, 8'h80);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            chk(s8_q == exp_trial(8'hA5, k), "R3 trial step", s8_q, exp_trial(8'hA5, k));
            chk(s8_ser == s8_tgt[8-k], "R5 serial bit", s8_ser, s8_tgt[8-k]);
            chk(s8_done == (k == 8), "R4 done timing", s8_done, (k == 8));
        end
        @(negedge clk);
        chk(!s8_done && s8_q == 8'hA5, "R4 single pulse and hold", {s8_done, s8_q}, 8'hA5);
        repeat (3) @(negedge clk);
        chk(s8_q == 8'hA5, "R4 result held", s8_q, 8'hA5);

        // R6: start pulse in mid conversion is ignored
        s8_tgt = 8'h3C;
        s8_start_drv = 1'b1;
        @(negedge clk);
        s8_start_drv = 1'b0;
        repeat (2) @(negedge clk);
        s8_start_drv = 1'b1;
        @(negedge clk);
        s8_start_drv = 1'b0;
        chk(s8_q == exp_trial(8'h3C, 3), "R6 start ignored", s8_q, exp_trial(8'h3C, 3));
        repeat (5) @(negedge clk);
        chk(s8_done && s8_q == 8'h3C, "R6 original schedule", {s8_done, s8_q}, {1'b1, 8'h3C});

        // R7: truncation in mid conversion withdraws bit 4
        s8_tgt = 8'hFF;
        s8_start_drv = 1'b1;
        @(negedge clk);
        s8_start_drv = 1'b0;
        repeat (3) @(negedge clk);
        s8_cut = 1'b1;
        @(negedge clk);
        s8_cut = 1'b0;
        chk(s8_done && s8_q == 8'hE0, "R7 truncate mid", {s8_done, s8_q}, {1'b1, 8'hE0});
        @(negedge clk);
        chk(!s8_done && s8_q == 8'hE0, "R7 truncated result held", {s8_done, s8_q}, 8'hE0);

        // R7: truncation colliding with the bit-0 decision
        s8_start_drv = 1'b1;
        @(negedge clk);
        s8_start_drv = 1'b0;
        repeat (7) @(negedge clk);
        s8_cut = 1'b1;
        @(negedge clk);
        s8_cut = 1'b0;
        chk(s8_done && s8_q == 8'hFE, "R7 collision at bit 0", {s8_done, s8_q}, {1'b1, 8'hFE});
        @(negedge clk);

        // R3, R4: directed corners then random targets with random gaps
        for (int i = 0; i < 48; i++) begin
            s8_tgt = (i < 4) ? fixed_t[i] : 8'($urandom);
            repeat ($urandom % 4) @(negedge clk);
            s8_start_drv = 1'b1;
            wait_done(n);
            chk(n == 9, "R4 latency", n, 9);
            chk(s8_q == s8_tgt, "R3 result", s8_q, s8_tgt);
        end

        // R6, R8: start held high gives back-to-back conversions
        s8_tgt = 8'($urandom);
        s8_start_drv = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!s8_done && n < 40);
        chk(s8_q == s8_tgt, "R6 held start result", s8_q, s8_tgt);
        for (int j = 0; j < 4; j++) begin
            s8_tgt = 8'($urandom);
            n = 0;
            do begin @(negedge clk); n++; end while (!s8_done && n < 40);
            chk(n == 9, "R8 held start cadence", n, 9);
            chk(s8_q == s8_tgt, "R6 held start result", s8_q, s8_tgt);
        end
        s8_start_drv = 1'b0;
        @(negedge clk);

        // R8: done fed back to start, every 8-bit code
        s8_tgt = 8'h00;
        s8_loop = 1'b1;
        s8_start_drv = 1'b1;
        for (int code = 0; code < 256; code++) begin
            wait_done(n);
            chk(n == 9, "R8 loop period", n, 9);
            chk(s8_q == 8'(code), "R8 loop result", s8_q, code);
            if (code == 255) s8_loop = 1'b0;
            else s8_tgt = 8'(code + 1);
        end

        wait (sh_fin && cas_fin);
        @(negedge clk);
        report();
        $finish;
    end

endmodule